// File: doc/BRIEF.md
# Floating-Point Issue Hazard Checker

This block sits in the decode stage of an in-order pipeline. Behind that stage are functional units with different latencies: an integer unit, a memory path, a pipelined FP adder, a pipelined FP multiplier and a non-pipelined FP divider. Each cycle it receives one decoded instruction: an operation class, up to two FP source registers with enable flags, and a destination register. It then decides whether the instruction may leave decode this cycle (`issue`) or must wait (`stall`). Nothing is queued. A waiting instruction is re-examined every cycle until every condition clears, and it may be withdrawn or replaced in the meantime.

Four conditions are checked. The divider has a busy window, because a second divide cannot start until the first has left its initiation interval. The single FP write port has a shift-register reservation, so two instructions never reach write-back in the same cycle. Each FP register has a countdown to the time its pending result can be forwarded, and this countdown gives the read-after-write check. The same countdown gives the write-after-write check, which keeps a short-latency writer from landing before an older, longer-latency writer of the same register. The defaults are latencies integer 0, memory 1, add 3, multiply 6, divide 24, and an initiation interval of 25 for the divider (1 for every other unit).

Top module: `fpi_issue_check`

## Requirements
- R1: With `id_valid` low, both `issue` and `stall` are low. With `id_valid` high, exactly one of them is high.
- R2: Class encoding on `id_class`: 0 integer, 1 FP load, 2 FP store, 3 FP add, 4 FP multiply, 5 FP divide; 6 and 7 behave as integer. Integer and store instructions never create a pending FP result, so a later FP reader of their `id_dst` field issues at once.
- R3: A reader of an FP register written by an instruction of latency L, issued in cycle t, stalls in cycles t+1 to t+L and issues in cycle t+L+1. L is 1 for load, 3 for add, 6 for multiply and 24 for divide.
- R4: A source whose enable flag is low never causes a stall, whatever register it names.
- R5: A divide issued in cycle t blocks every other divide until cycle t+25. Add, multiply and load instructions can issue on consecutive cycles.
- R6: An FP-writing instruction stalls if its write-back slot (issue cycle plus latency) equals that of an FP writer already issued. Example: a multiply in cycle t stalls an independent add presented in cycle t+3 for one cycle.
- R7: An FP writer of latency L, targeting a register whose pending writer still has c cycles to go, stalls while c is nonzero and L is at most c. A multiply to a register stalls a following load to it for 6 cycles and a following add to it for 4 cycles. A following longer-latency writer is not delayed.
- R8: A stalled instruction changes no state. If it is withdrawn, its destination holds no pending result and it leaves no unit busy. Waiting instructions are re-judged every cycle against the current state.
- R9: Reset clears all pending results, the write-port reservations and the divider busy window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| id_valid | input | 1 | An instruction is present in decode |
| id_class | input | 3 | Operation class (encoding in R2) |
| id_src_a | input | 5 | First FP source register |
| id_src_a_en | input | 1 | First source is read |
| id_src_b | input | 5 | Second FP source register |
| id_src_b_en | input | 1 | Second source is read |
| id_dst | input | 5 | FP destination register (used by writing classes) |
| issue | output | 1 | Instruction leaves decode this cycle |
| stall | output | 1 | Instruction is held in decode this cycle |

## Verification
The hardest case to reach is an instruction that is held for one reason and then finds that the state has moved on while it waited. One example is a second divide that is withdrawn after a few stalled cycles. Another is a write-port collision that exists in only one cycle of the shift register's motion. The directed scenarios place each instruction on an exact cycle offset from its producer, using idle cycles between the two. They present the divide, let it stall for three cycles and then withdraw it. They then confirm two things at the ports: that it left no pending result behind, and that a later divide waits out only the remaining 20 cycles of the first divide's window.

// File: rtl/fpi_pkg.sv
package fpi_pkg;

    typedef enum logic [2:0] {
        CLS_INT    = 3'd0,
        CLS_FLOAD  = 3'd1,
        CLS_FSTORE = 3'd2,
        CLS_FADD   = 3'd3,
        CLS_FMUL   = 3'd4,
        CLS_FDIV   = 3'd5,
        CLS_RSV6   = 3'd6,
        CLS_RSV7   = 3'd7
    } op_class_e;

    localparam int NUM_UNITS = 5;
    localparam int UNIT_W    = 3;

    typedef enum logic [UNIT_W-1:0] {
        U_INT = 3'd0,
        U_MEM = 3'd1,
        U_ADD = 3'd2,
        U_MUL = 3'd3,
        U_DIV = 3'd4
    } unit_e;

    function automatic int fpi_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/fpi_class_decode.sv
module fpi_class_decode
    import fpi_pkg::*;
#(
    parameter int LW      = 5,
    parameter int LAT_INT = 0,
    parameter int LAT_MEM = 1,
    parameter int LAT_ADD = 3,
    parameter int LAT_MUL = 6,
    parameter int LAT_DIV = 24
) (
    input  logic [2:0]        cls_i,
    output logic [LW-1:0]     lat_o,
    output logic              wr_fp_o,
    output logic [UNIT_W-1:0] unit_o
);

    op_class_e cls;
    assign cls = op_class_e'(cls_i);

    always_comb begin
        lat_o   = LW'(LAT_INT);
        wr_fp_o = 1'b0;
        unit_o  = U_INT;
        unique case (cls)
            CLS_FLOAD: begin
                lat_o   = LW'(LAT_MEM);
                wr_fp_o = 1'b1;
                unit_o  = U_MEM;
            end
            CLS_FSTORE: begin
                lat_o   = LW'(LAT_MEM);
                wr_fp_o = 1'b0;
                unit_o  = U_MEM;
            end
            CLS_FADD: begin
                lat_o   = LW'(LAT_ADD);
                wr_fp_o = 1'b1;
                unit_o  = U_ADD;
            end
            CLS_FMUL: begin
                lat_o   = LW'(LAT_MUL);
                wr_fp_o = 1'b1;
                unit_o  = U_MUL;
            end
            CLS_FDIV: begin
                lat_o   = LW'(LAT_DIV);
                wr_fp_o = 1'b1;
                unit_o  = U_DIV;
            end
            default: begin
                lat_o   = LW'(LAT_INT);
                wr_fp_o = 1'b0;
                unit_o  = U_INT;
            end
        endcase
    end

endmodule

// File: rtl/fpi_unit_busy.sv
module fpi_unit_busy
    import fpi_pkg::*;
#(
    parameter int                     NUM    = 5,
    parameter int                     II_W   = 8,
    parameter logic [NUM*II_W-1:0]    II_VEC = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire_i,
    input  logic [UNIT_W-1:0] unit_i,
    output logic [NUM-1:0]    busy_o
);

    for (genvar u = 0; u < NUM; u++) begin : g_unit
        localparam int IIU = int'(II_VEC[u*II_W +: II_W]);

        if (IIU > 1) begin : g_counted
            typedef struct packed {
                logic [II_W-1:0] cnt;
            } busy_st_t;

            busy_st_t st_d, st_q;
            logic     hit;

            assign hit = fire_i && (unit_i == UNIT_W'(u));

            always_comb begin
                st_d = st_q;
                if (st_q.cnt != '0) begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end
                if (hit) begin
                    st_d.cnt = II_W'(IIU - 1);
                end
            end

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    st_q <= '0;
                end else begin
                    st_q <= st_d;
                end
            end

            assign busy_o[u] = (st_q.cnt != '0);

            AST_UNIT_GAP: assert property (@(posedge clk) disable iff (!rst_n)
                hit |=> !(fire_i && (unit_i == UNIT_W'(u))))
                else $error("unit restarted inside its interval"); // R5
        end else begin : g_free
            assign busy_o[u] = 1'b0;
        end
    end

endmodule

// File: rtl/fpi_wport_resv.sv
module fpi_wport_resv #(
    parameter int DEPTH = 25,
    parameter int LW    = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fire_i,
    input  logic          wr_en_i,
    input  logic [LW-1:0] lat_i,
    output logic          conflict_o
);

    typedef struct packed {
        logic [DEPTH-1:0] slot;
    } resv_st_t;

    resv_st_t         st_d, st_q;
    logic             slot_taken;
    logic [DEPTH-1:0] new_bit;

    assign slot_taken = (int'(lat_i) < DEPTH) && st_q.slot[lat_i];
    assign conflict_o = wr_en_i && slot_taken;

    always_comb begin
        new_bit = ({{(DEPTH-1){1'b0}}, 1'b1} << lat_i) >> 1;
        st_d    = st_q;
        st_d.slot = st_q.slot >> 1;
        if (fire_i && wr_en_i) begin
            st_d.slot = st_d.slot | new_bit;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_WPORT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_i && wr_en_i) |-> !slot_taken)
        else $error("two writers share a write-back slot"); // R6

endmodule

// File: rtl/fpi_reg_timers.sv
module fpi_reg_timers #(
    parameter int NREG = 32,
    parameter int RW   = 5,
    parameter int LW   = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fire_i,
    input  logic          wr_en_i,
    input  logic [RW-1:0] wr_reg_i,
    input  logic [LW-1:0] wr_lat_i,
    input  logic [RW-1:0] rd_a_i,
    input  logic          rd_a_en_i,
    input  logic [RW-1:0] rd_b_i,
    input  logic          rd_b_en_i,
    output logic          raw_o,
    output logic          waw_o
);

    typedef struct packed {
        logic [NREG-1:0][LW-1:0] cnt;
    } tmr_st_t;

    tmr_st_t       st_d, st_q;
    logic [LW-1:0] cnt_a, cnt_b, cnt_w;

    assign cnt_a = st_q.cnt[rd_a_i];
    assign cnt_b = st_q.cnt[rd_b_i];
    assign cnt_w = st_q.cnt[wr_reg_i];

    assign raw_o = (rd_a_en_i && (cnt_a != '0)) || (rd_b_en_i && (cnt_b != '0));
    assign waw_o = wr_en_i && (cnt_w != '0) && (wr_lat_i <= cnt_w);

    always_comb begin
        st_d = st_q;
        for (int r = 0; r < NREG; r++) begin
            if (st_q.cnt[r] != '0) begin
                st_d.cnt[r] = st_q.cnt[r] - 1'b1;
            end
            if (fire_i && wr_en_i && (wr_reg_i == RW'(r))) begin
                st_d.cnt[r] = wr_lat_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_RAW_SRC_A: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_i && rd_a_en_i) |-> (cnt_a == '0))
        else $error("source A read before ready"); // R3

    AST_RAW_SRC_B: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_i && rd_b_en_i) |-> (cnt_b == '0))
        else $error("source B read before ready"); // R3

    AST_WAW_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_i && wr_en_i) |-> ((cnt_w == '0) || (wr_lat_i > cnt_w)))
        else $error("younger writer overtakes older one"); // R7

endmodule

// File: rtl/fpi_issue_check.sv
module fpi_issue_check
    import fpi_pkg::*;
#(
    parameter int NREG    = 32,
    parameter int LAT_INT = 0,
    parameter int LAT_MEM = 1,
    parameter int LAT_ADD = 3,
    parameter int LAT_MUL = 6,
    parameter int LAT_DIV = 24,
    parameter int II_INT  = 1,
    parameter int II_MEM  = 1,
    parameter int II_ADD  = 1,
    parameter int II_MUL  = 1,
    parameter int II_DIV  = 25
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       id_valid,
    input  logic [2:0] id_class,
    input  logic [4:0] id_src_a,
    input  logic       id_src_a_en,
    input  logic [4:0] id_src_b,
    input  logic       id_src_b_en,
    input  logic [4:0] id_dst,
    output logic       issue,
    output logic       stall
);

    localparam int MAX_LAT = fpi_max(fpi_max(fpi_max(LAT_INT, LAT_MEM),
                                             fpi_max(LAT_ADD, LAT_MUL)), LAT_DIV);
    localparam int LW      = $clog2(MAX_LAT + 1);
    localparam int RW      = $clog2(NREG);
    localparam int II_W    = 8;
    localparam logic [NUM_UNITS*II_W-1:0] II_VEC =
        {II_W'(II_DIV), II_W'(II_MUL), II_W'(II_ADD), II_W'(II_MEM), II_W'(II_INT)};

    logic [LW-1:0]        lat;
    logic                 wr_fp;
    logic [UNIT_W-1:0]    unit;
    logic [NUM_UNITS-1:0] busy;
    logic                 struct_hit, port_hit, raw_hit, waw_hit;
    logic                 any_hit, fire;

    fpi_class_decode #(
        .LW      (LW),
        .LAT_INT (LAT_INT),
        .LAT_MEM (LAT_MEM),
        .LAT_ADD (LAT_ADD),
        .LAT_MUL (LAT_MUL),
        .LAT_DIV (LAT_DIV)
    ) u_decode (
        .cls_i   (id_class),
        .lat_o   (lat),
        .wr_fp_o (wr_fp),
        .unit_o  (unit)
    );

    fpi_unit_busy #(
        .NUM    (NUM_UNITS),
        .II_W   (II_W),
        .II_VEC (II_VEC)
    ) u_busy (
        .clk    (clk),
        .rst_n  (rst_n),
        .fire_i (fire),
        .unit_i (unit),
        .busy_o (busy)
    );

    fpi_wport_resv #(
        .DEPTH (MAX_LAT + 1),
        .LW    (LW)
    ) u_wport (
        .clk        (clk),
        .rst_n      (rst_n),
        .fire_i     (fire),
        .wr_en_i    (wr_fp),
        .lat_i      (lat),
        .conflict_o (port_hit)
    );

    fpi_reg_timers #(
        .NREG (NREG),
        .RW   (RW),
        .LW   (LW)
    ) u_timers (
        .clk       (clk),
        .rst_n     (rst_n),
        .fire_i    (fire),
        .wr_en_i   (wr_fp),
        .wr_reg_i  (RW'(id_dst)),
        .wr_lat_i  (lat),
        .rd_a_i    (RW'(id_src_a)),
        .rd_a_en_i (id_src_a_en),
        .rd_b_i    (RW'(id_src_b)),
        .rd_b_en_i (id_src_b_en),
        .raw_o     (raw_hit),
        .waw_o     (waw_hit)
    );

    assign struct_hit = busy[unit];
    assign any_hit    = struct_hit || port_hit || raw_hit || waw_hit;
    assign fire       = id_valid && !any_hit;
    assign issue      = fire;
    assign stall      = id_valid && any_hit;

    AST_ONE_DECISION: assert property (@(posedge clk) disable iff (!rst_n)
        id_valid |-> (issue != stall))
        else $error("issue and stall disagree"); // R1

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !id_valid |-> (!issue && !stall))
        else $error("decision without an instruction"); // R1

endmodule

// File: tb/fpi_issue_check_tb.sv
module fpi_issue_check_tb;

    localparam logic [2:0] C_INT = 3'd0, C_LD = 3'd1, C_ST = 3'd2,
                            C_ADD = 3'd3, C_MUL = 3'd4, C_DIV = 3'd5;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       id_valid;
    logic [2:0] id_class;
    logic [4:0] id_src_a, id_src_b, id_dst;
    logic       id_src_a_en, id_src_b_en;
    logic       issue, stall;

    int n_checks = 0;
    int n_fails  = 0;

    always #4 clk = ~clk;

    fpi_issue_check u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .id_valid    (id_valid),
        .id_class    (id_class),
        .id_src_a    (id_src_a),
        .id_src_a_en (id_src_a_en),
        .id_src_b    (id_src_b),
        .id_src_b_en (id_src_b_en),
        .id_dst      (id_dst),
        .issue       (issue),
        .stall       (stall)
    );

    task automatic check(input int act, input int exp, input string req);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic present(input logic [2:0] c, input logic [4:0] sa, input logic sae,
                           input logic [4:0] sb, input logic sbe, input logic [4:0] d);
        id_valid    = 1'b1;
        id_class    = c;
        id_src_a    = sa;
        id_src_a_en = sae;
        id_src_b    = sb;
        id_src_b_en = sbe;
        id_dst      = d;
    endtask

    // Starts at a falling edge; returns at the falling edge after the issue cycle.
    task automatic go(input logic [2:0] c, input logic [4:0] sa, input logic sae,
                      input logic [4:0] sb, input logic sbe, input logic [4:0] d,
                      output int stalls);
        stalls = 0;
        present(c, sa, sae, sb, sbe, d);
        for (int k = 0; k < 200; k++) begin
            #1;
            if (issue) break;
            if (stall !== 1'b1) check(0, 1, "R1 stall while held");
            stalls++;
            @(negedge clk);
        end
        @(negedge clk);
        id_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        id_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset_state();
        int s;
        #1;
        check(int'(issue), 0, "R9 issue low in reset");
        check(int'(stall), 0, "R9 stall low in reset");
        rst_n = 1'b1;
        @(negedge clk);
        go(C_ADD, 5'd0, 1'b0, 5'd0, 1'b0, 5'd1, s);
        check(s, 0, "R9 first instruction after reset");
        #1;
        check(int'(issue | stall), 0, "R1 idle gives no decision");
        idle(30);
    endtask

    task automatic t_raw();
        int s;
        go(C_LD,  5'd0, 1'b0, 5'd0, 1'b0, 5'd1, s);
        go(C_ADD, 5'd1, 1'b1, 5'd0, 1'b0, 5'd2, s);
        check(s, 1, "R3 load to add");
        idle(30);
        go(C_ADD, 5'd0, 1'b0, 5'd0, 1'b0, 5'd3, s);
        go(C_MUL, 5'd8, 1'b0, 5'd3, 1'b1, 5'd4, s);
        check(s, 3, "R3 add to mul via source B");
        idle(30);
        go(C_MUL, 5'd0, 1'b0, 5'd0, 1'b0, 5'd4, s);
        go(C_ADD, 5'd4, 1'b1, 5'd0, 1'b0, 5'd5, s);
        check(s, 6, "R3 mul to add");
        idle(30);
        go(C_DIV, 5'd0, 1'b0, 5'd0, 1'b0, 5'd5, s);
        go(C_ADD, 5'd5, 1'b1, 5'd0, 1'b0, 5'd6, s);
        check(s, 24, "R3 div to add");
        idle(30);
    endtask

    task automatic t_src_enable();
        int s;
        go(C_ADD, 5'd0, 1'b0, 5'd0, 1'b0, 5'd6, s);
        go(C_ADD, 5'd6, 1'b0, 5'd0, 1'b1, 5'd7, s);
        check(s, 0, "R4 disabled source ignored");
        idle(30);
    endtask

    task automatic t_int_store();
        int s;
        go(C_INT, 5'd0, 1'b0, 5'd0, 1'b0, 5'd8, s);
        go(C_ADD, 5'd8, 1'b1, 5'd0, 1'b0, 5'd10, s);
        check(s, 0, "R2 integer leaves no FP pending");
        idle(30);
        go(C_ST,  5'd0, 1'b0, 5'd0, 1'b0, 5'd11, s);
        go(C_ADD, 5'd11, 1'b1, 5'd0, 1'b0, 5'd12, s);
        check(s, 0, "R2 store leaves no FP pending");
        idle(30);
        go(C_ADD, 5'd0, 1'b0, 5'd0, 1'b0, 5'd9, s);
        go(C_ST,  5'd9, 1'b1, 5'd0, 1'b0, 5'd0, s);
        check(s, 3, "R2 store waits for its FP source");
        idle(30);
    endtask

    task automatic t_structural();
        int s;
        go(C_DIV, 5'd0, 1'b0, 5'd0, 1'b0, 5'd10, s);
        go(C_DIV, 5'd0, 1'b0, 5'd0, 1'b0, 5'd11, s);
        check(s, 24, "R5 divide interval");
        idle(30);
        go(C_ADD, 5'd0, 1'b0, 5'd0, 1'b0, 5'd12, s);
        go(C_ADD, 5'd0, 1'b0, 5'd0, 1'b0, 5'd13, s);
        check(s, 0, "R5 adds back to back");
        go(C_MUL, 5'd0, 1'b0, 5'd0, 1'b0, 5'd14, s);
        go(C_MUL, 5'd0, 1'b0, 5'd0, 1'b0, 5'd15, s);
        check(s, 0, "R5 muls back to back");
        idle(30);
    endtask

    task automatic t_write_port();
        int s;
        go(C_MUL, 5'd0, 1'b0, 5'd0, 1'b0, 5'd17, s);
        idle(2);
        go(C_ADD, 5'd0, 1'b0, 5'd0, 1'b0, 5'd18, s);
        check(s, 1, "R6 add collides with mul slot");
        idle(30);
        go(C_ADD, 5'd0, 1'b0, 5'd0, 1'b0, 5'd19, s);
        idle(1);
        go(C_LD,  5'd0, 1'b0, 5'd0, 1'b0, 5'd20, s);
        check(s, 1, "R6 load collides with add slot");
        idle(30);
    endtask

    task automatic t_waw();
        int s;
        go(C_MUL, 5'd0, 1'b0, 5'd0, 1'b0, 5'd2, s);
        go(C_LD,  5'd0, 1'b0, 5'd0, 1'b0, 5'd2, s);
        check(s, 6, "R7 load behind mul same dst");
        idle(30);
        go(C_MUL, 5'd0, 1'b0, 5'd0, 1'b0, 5'd2, s);
        go(C_ADD, 5'd0, 1'b0, 5'd0, 1'b0, 5'd2, s);
        check(s, 4, "R7 add behind mul same dst");
        idle(30);
        go(C_ADD, 5'd0, 1'b0, 5'd0, 1'b0, 5'd21, s);
        go(C_MUL, 5'd0, 1'b0, 5'd0, 1'b0, 5'd21, s);
        check(s, 0, "R7 longer writer not delayed");
        idle(30);
    endtask

    task automatic t_hold_withdraw();
        int s;
        int held;
        go(C_DIV, 5'd0, 1'b0, 5'd0, 1'b0, 5'd22, s);
        present(C_DIV, 5'd0, 1'b0, 5'd0, 1'b0, 5'd23);
        held = 0;
        repeat (3) begin
            #1;
            if (stall === 1'b1 && issue === 1'b0) held++;
            @(negedge clk);
        end
        check(held, 3, "R8 second divide held");
        go(C_ADD, 5'd23, 1'b1, 5'd0, 1'b0, 5'd25, s);
        check(s, 0, "R8 withdrawn divide left no pending result");
        go(C_DIV, 5'd0, 1'b0, 5'd0, 1'b0, 5'd24, s);
        check(s, 20, "R8 re-judged divide waits remaining window");
        idle(30);
    endtask

    task automatic t_reset_mid();
        int s;
        go(C_DIV, 5'd0, 1'b0, 5'd0, 1'b0, 5'd26, s);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        go(C_ADD, 5'd26, 1'b1, 5'd0, 1'b0, 5'd27, s);
        check(s, 0, "R9 reset clears pending result");
        go(C_DIV, 5'd0, 1'b0, 5'd0, 1'b0, 5'd28, s);
        check(s, 0, "R9 reset clears divider window");
        idle(30);
    endtask

    initial begin
        rst_n       = 1'b0;
        id_valid    = 1'b0;
        id_class    = '0;
        id_src_a    = '0;
        id_src_a_en = 1'b0;
        id_src_b    = '0;
        id_src_b_en = 1'b0;
        id_dst      = '0;
        repeat (3) @(negedge clk);
        t_reset_state();
        t_raw();
        t_src_enable();
        t_int_store();
        t_structural();
        t_write_port();
        t_waw();
        t_hold_withdraw();
        t_reset_mid();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(8 * 150000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule